// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block is the register front end of a 32-pin general-purpose I/O bank. Each 32-bit logical register is stored as two 16-bit halves at consecutive word addresses. The lower word holds pins 0 to 15 and the upper word holds pins 16 to 31. Every write carries its own bit-enables in the upper sixteen bits of the write data. Software can therefore set, clear or change any single pin in one bus write, without first reading the register. This makes the update atomic with respect to other agents that share the bank.

The block holds an output-value register and a direction register, and it drives the pad output and output-enable vectors straight from them. A read-only pad-level register returns the pad inputs after a two-stage synchronizer. Access is over a simple word bus: a byte address, a write strobe, write data, and combinational read data. The asynchronous active-low reset is released synchronously inside the block.

Top module: `gpio_mw_bank`

## Requirements
- R1: After reset the output-value and direction registers are all zero, so pad_out and pad_oe are 0 and every pin is an input.
- R2: In a write to a writable half, bit n+16 of the write data enables an update of stored bit n to write-data bit n. Stored bits whose enable bit is 0 keep their value.
- R3: The half at a register's base address covers pins 0 to 15, and the half at base+4 covers pins 16 to 31. A write to one half never alters the other half.
- R4: A read of any half returns its 16 pin values in bits 15:0, and bits 31:16 of read data are always 0.
- R5: pad_out[n] equals output-value bit n, and pad_oe[n] equals direction bit n, where 1 means the pin is an output.
- R6: The output-value register is at 0x00/0x04, the direction register at 0x08/0x0C, and the pad-level register at 0x70/0x74. The pad-level register is read-only, and a write to it changes no register.
- R7: A change on pad_in becomes visible in the pad-level register after exactly two rising clock edges.
- R8: A write to any other address changes nothing, and a read of any other address returns 0. Unaligned addresses count as other addresses.
- R9: A read of the output-value or direction half returns the value currently stored in that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |

## Verification
The masked write is tried with three kinds of enable pattern. Full enables separate a plain store from a masked one. A single enable bit with a zero value shows that only one pin moves. Data with no enables at all shows that nothing moves. The same patterns go to the upper half, which separates correct half steering from a block that folds both halves onto one. Writes to the read-only and unmapped addresses are each followed by readback and pad checks. A pad-level step is sampled one edge and two edges after it arrives, which fixes the synchronizer depth.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int WORD_BYTES = 4;
  localparam int OUTVAL_BASE = 'h00;
  localparam int DIR_BASE = 'h08;
  localparam int PADLVL_BASE = 'h70;
endpackage

// File: rtl/gpio_mw_half_reg.sv
module gpio_mw_half_reg #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2*HALF_W-1:0]   wr_word,
  output logic [HALF_W-1:0]     q
);
  logic [HALF_W-1:0] en_bits;
  logic [HALF_W-1:0] val_bits;
  logic [HALF_W-1:0] q_nxt;

  always_comb begin
    en_bits  = wr_word[2*HALF_W-1:HALF_W];
    val_bits = wr_word[HALF_W-1:0];
    q_nxt    = (q & ~en_bits) | (val_bits & en_bits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      q <= q_nxt;
    end
  end

  // R2: bits without an enable hold their value through a write
  p_masked_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~$past(wr_word[2*HALF_W-1:HALF_W])) ==
               ($past(q) & ~$past(wr_word[2*HALF_W-1:HALF_W]))));

  // R2: enabled bits take the written value
  p_masked_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(wr_word[2*HALF_W-1:HALF_W])) ==
               ($past(wr_word[HALF_W-1:0]) & $past(wr_word[2*HALF_W-1:HALF_W]))));
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

  // R7: two-edge latency from pad to register
  p_sync_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 2*HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  localparam int NUM_HALVES = PINS / HALF_W;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  logic [PINS-1:0]       outval_q;
  logic [PINS-1:0]       dir_q;
  logic [PINS-1:0]       padlvl_q;
  logic [NUM_HALVES-1:0] outval_wr;
  logic [NUM_HALVES-1:0] dir_wr;
  logic [HALF_W-1:0]     rd_half;

  // address decode for writes and the read mux
  always_comb begin
    outval_wr = '0;
    dir_wr    = '0;
    rd_half   = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (bus_addr == ADDR_W'(OUTVAL_BASE + h*WORD_BYTES)) begin
        outval_wr[h] = bus_we;
        rd_half      = outval_q[h*HALF_W +: HALF_W];
      end
      if (bus_addr == ADDR_W'(DIR_BASE + h*WORD_BYTES)) begin
        dir_wr[h] = bus_we;
        rd_half   = dir_q[h*HALF_W +: HALF_W];
      end
      if (bus_addr == ADDR_W'(PADLVL_BASE + h*WORD_BYTES)) begin
        rd_half = padlvl_q[h*HALF_W +: HALF_W];
      end
    end
    bus_rdata = {{(DATA_W-HALF_W){1'b0}}, rd_half};
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    gpio_mw_half_reg #(.HALF_W(HALF_W)) u_outval (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (outval_wr[h]),
      .wr_word (bus_wdata),
      .q       (outval_q[h*HALF_W +: HALF_W])
    );
    gpio_mw_half_reg #(.HALF_W(HALF_W)) u_dir (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_en   (dir_wr[h]),
      .wr_word (bus_wdata),
      .q       (dir_q[h*HALF_W +: HALF_W])
    );
  end

  gpio_mw_sync #(.W(PINS)) u_padsync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pad_in),
    .q     (padlvl_q)
  );

  always_comb begin
    pad_out = outval_q;
    pad_oe  = dir_q;
  end

  // R4: upper read bits stay zero
  p_rd_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_rdata[DATA_W-1:HALF_W] == '0);

  // R6: writes to the pad-level words leave every register alone
  p_padlvl_ro_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && (bus_addr == ADDR_W'(PADLVL_BASE) ||
                bus_addr == ADDR_W'(PADLVL_BASE + WORD_BYTES)))
    |=> ($stable(outval_q) && $stable(dir_q)));

  // R8: a write that hits no writable half changes nothing
  p_unmapped_wr_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && (bus_addr[1:0] != 2'b00)) |=> ($stable(outval_q) && $stable(dir_q)));

  // R3: a write to the lower output half leaves the upper half alone
  p_half_isolate_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == ADDR_W'(OUTVAL_BASE))
    |=> $stable(outval_q[PINS-1:HALF_W]));
endmodule

// File: tb/gpio_mw_bank_bench.sv
module gpio_mw_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] m_out = '0;
  logic [31:0] m_dir = '0;

  always #5 clk = ~clk;

  gpio_mw_bank u_gpio_mw_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 8'h00) m_out[15:0]  = merge(m_out[15:0], d);
    if (a == 8'h04) m_out[31:16] = merge(m_out[31:16], d);
    if (a == 8'h08) m_dir[15:0]  = merge(m_dir[15:0], d);
    if (a == 8'h0C) m_dir[31:16] = merge(m_dir[31:16], d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [31:0] r;
    bus_read(8'h00, r); check(req, r, {16'h0, m_out[15:0]});
    bus_read(8'h04, r); check(req, r, {16'h0, m_out[31:16]});
    bus_read(8'h08, r); check(req, r, {16'h0, m_dir[15:0]});
    bus_read(8'h0C, r); check(req, r, {16'h0, m_dir[31:16]});
    check(req, pad_out, m_out);
    check(req, pad_oe, m_dir);
  endtask

  task automatic t_reset;
    check_regs("R1 reset state");
  endtask

  task automatic t_masked_lower;
    bus_write(8'h00, 32'hFFFF_A5A5);
    check_regs("R9 full write readback");
    bus_write(8'h00, 32'h0001_0000);
    check_regs("R2 single enable clears bit0");
    check("R2 bit0 value", {31'h0, pad_out[0]}, 32'h0);
    bus_write(8'h00, 32'h0000_FFFF);
    check_regs("R2 no enables no change");
  endtask

  task automatic t_upper_half;
    bus_write(8'h04, 32'h00FF_1234);
    check_regs("R3 upper half steering");
    check("R3 lower half intact", {16'h0, pad_out[15:0]}, 32'h0000_A5A4);
  endtask

  task automatic t_direction;
    bus_write(8'h08, 32'hFFFF_00F0);
    bus_write(8'h0C, 32'h8000_8000);
    check_regs("R5 direction to pad_oe");
    check("R5 pin31 output", {31'h0, pad_oe[31]}, 32'h1);
  endtask

  task automatic t_readonly_unmapped;
    logic [31:0] r;
    bus_write(8'h70, 32'hFFFF_FFFF);
    bus_write(8'h74, 32'hFFFF_FFFF);
    check_regs("R6 pad-level write ignored");
    bus_write(8'h10, 32'hFFFF_FFFF);
    bus_write(8'h02, 32'hFFFF_FFFF);
    bus_write(8'h09, 32'hFFFF_0000);
    check_regs("R8 unmapped write ignored");
    bus_read(8'h10, r); check("R8 unmapped read zero", r, 32'h0);
    bus_read(8'h01, r); check("R8 unaligned read zero", r, 32'h0);
  endtask

  task automatic t_pad_sync;
    logic [31:0] r;
    @(negedge clk);
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_read(8'h70, r); check("R7 one edge still old", r, 32'h0);
    @(negedge clk);
    bus_read(8'h70, r); check("R7 lower after two edges", r, 32'h0000_BEEF);
    bus_read(8'h74, r); check("R4 upper after two edges", r, 32'h0000_DEAD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_masked_lower();
    t_upper_half();
    t_direction();
    t_readonly_unmapped();
    t_pad_sync();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule